// File: doc/BRIEF.md
# External Status Change Latch

This block watches the line and modem conditions of one serial channel and reports them as one status byte. The conditions are carrier detect, clear-to-send, sync/hunt, a break/abort level from the receive detector, and the transmit underrun/end-of-message flag. When an enabled condition changes, the block freezes the three line bits and raises one shared interrupt request. Software reads the frozen byte and then issues a release command. After the release, the bits follow their inputs again. Any change that was left unreported when the release arrived raises a fresh request one cycle later.

Break/abort is handled apart from the other bits. Each of its edges is guaranteed to produce a request, even when a request is already pending. The underrun flag is a set/clear latch that requests only when it goes from 0 to 1. In asynchronous mode with the crystal option selected, sync/hunt is forced off. The request output is the pending flag gated by a master enable.

Top module: `extstat_latch`

## Requirements
- R1: The status byte is, from bit 7 down to bit 0: break/abort, underrun/EOM, CTS, sync/hunt, DCD, zero count, Tx buffer empty, Rx character available. Bits 2..0 pass the inputs `zero_cnt`, `tx_buf_empty` and `rx_char_avail` through without a register.
- R2: While `rst_n` is low, `irq` is 0 and the underrun/EOM bit (bit 6) is 1. With idle inputs (all `line_n` high, all other inputs low), the byte reads 8'h40.
- R3: `line_n[0]` is DCD (status bit 3), `line_n[1]` is sync/hunt (bit 4) and `line_n[2]` is CTS (bit 5). A condition is true when its pin is low. If `ie_mask[i]` is 1 and no request is pending, a change on `line_n[i]` at a clock edge captures the new value into the bit and sets the pending flag at that same edge.
- R4: While the pending flag is set, the latched line bits whose enable is set keep their captured value, whatever their pins do.
- R5: A `rst_es` cycle clears the pending flag at the next edge. At the edge after that, any enabled line whose pin now differs from its latched value sets the flag again. An odd number of toggles during the pending time therefore gives a new request, and an even number gives none.
- R6: When `ie_mask[i]` is 0, status bit 3+i shows the inverted live pin with no register in the path, and that line never sets the pending flag.
- R7: With `ie_mask[4]` set, each rising or falling edge of `brk_det` sets the pending flag, and status bit 7 shows `brk_det` one cycle late. An edge that arrives while a request is pending, or in the same cycle as `rst_es`, leaves the flag set after the release.
- R8: The underrun/EOM bit is set by `eom_set` and cleared only by `undr_clr`; set wins when both are high. With `ie_mask[3]` set, only its 0-to-1 transition sets the pending flag.
- R9: When `async_mode` and `xtal_sel` are both 1, sync/hunt reads 0 and cannot set the pending flag. With `async_mode` at 0, `xtal_sel` has no effect.
- R10: `irq` equals the pending flag ANDed with `mie`. Clearing `mie` does not discard a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_n | input | 3 | Synchronized active-low DCD, sync/hunt, CTS pins |
| brk_det | input | 1 | Break/abort detector level |
| zero_cnt | input | 1 | Baud counter zero-count status |
| tx_buf_empty | input | 1 | Transmit buffer empty status |
| rx_char_avail | input | 1 | Receive character available status |
| eom_set | input | 1 | Pulse: underrun, transmitter disable or send-abort |
| undr_clr | input | 1 | Pulse: clear underrun/EOM command |
| rst_es | input | 1 | Pulse: release latches and clear pending request |
| ie_mask | input | 5 | Enables: [0] DCD, [1] sync, [2] CTS, [3] underrun, [4] break |
| async_mode | input | 1 | 1 = asynchronous mode, 0 = synchronous mode |
| xtal_sel | input | 1 | Crystal oscillator option selected |
| mie | input | 1 | Master interrupt enable |
| status | output | 8 | Status byte |
| irq | output | 1 | External/status interrupt request |

## Verification
The bench steps each of the three lines through zero to three toggles while a request is pending, and then checks whether a fresh request follows the release. A design that compared only edges would miss the odd case. A design that ignored parity would fire on the even case. Break edges are sent during a pending request and also in the same cycle as the release, to catch a design that treats break like the other bits and loses the second request. The underrun flag is driven to an already-set state, to a clear, and to a set/clear collision, which exposes requests on the wrong edge and wrong priority. Forcing sync/hunt, masked lines and the master enable are each swept so that a leaked request or a latched read shows up at the ports.

// File: rtl/extstat_pkg.sv
// Shared sizes and bit positions for the external/status latch.
package extstat_pkg;
    localparam int NLINE    = 3;          // latched modem lines
    localparam int STAT_W   = 8;          // status byte width
    localparam int IE_W     = NLINE + 2;  // line enables + underrun + break
    localparam int LN_DCD   = 0;
    localparam int LN_SYNC  = 1;
    localparam int LN_CTS   = 2;
    localparam int IE_UNDR  = NLINE;
    localparam int IE_BRK   = NLINE + 1;
    localparam int SB_LINE0 = 3;          // first latched line bit
    localparam int SB_EOM   = 6;
    localparam int SB_BRK   = 7;
endpackage

// File: rtl/extstat_line.sv
// One latched condition line.
// The latch follows the live value while no request is pending and holds while one is.
// A change is reported only when the line is enabled, not forced off and not held.
// Assumes `live` is already synchronized and active-high.
module extstat_line (
    input  logic clk,
    input  logic rst_n,
    input  logic live,
    input  logic en,
    input  logic hold,
    input  logic force_off,
    output logic shown,
    output logic change
);
    logic lat;

    // Track the live value unless a request is pending.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lat <= 1'b0;
        else if (!hold)
            lat <= live;
    end

    // Report a change and choose between the latched and the live view.
    always_comb begin
        change = en & ~force_off & ~hold & (live ^ lat);
        if (force_off)
            shown = 1'b0;
        else if (en)
            shown = lat;
        else
            shown = live;
    end
endmodule

// File: rtl/extstat_eom.sv
// Underrun/EOM set/clear latch.
// Reset and `set` drive the flag to 1. Only `clr` drives it to 0, and set wins over clear.
// `rise` marks an enabled 0-to-1 transition in the current cycle.
module extstat_eom (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic en,
    output logic flag,
    output logic rise
);
    // Hold the underrun/EOM state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b1;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    // Flag a request-worthy rising transition.
    always_comb rise = en & set & ~flag;
endmodule

// File: rtl/extstat_pend.sv
// Pending-request controller.
// Line changes and underrun rises set the flag. Break edges also set it, and a break edge
// seen while a request is pending is remembered so that it survives the next release.
// Assumes the line change inputs are already masked by the hold.
module extstat_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic line_set,
    input  logic eom_rise,
    input  logic brk_edge,
    input  logic rst_es,
    output logic pend
);
    logic owe;

    // Update the pending flag and the owed break request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            owe  <= 1'b0;
        end else if (rst_es) begin
            pend <= owe | brk_edge | eom_rise;
            owe  <= 1'b0;
        end else begin
            pend <= pend | line_set | eom_rise | brk_edge;
            owe  <= owe | (pend & brk_edge);
        end
    end
endmodule

// File: rtl/extstat_latch.sv
// External/status change latch: builds the status byte and the shared interrupt request.
// Assumes all condition inputs are synchronized to clk. Break/abort and underrun come
// from detectors outside this block as a level and a pulse.
module extstat_latch
    import extstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINE-1:0]  line_n,
    input  logic              brk_det,
    input  logic              zero_cnt,
    input  logic              tx_buf_empty,
    input  logic              rx_char_avail,
    input  logic              eom_set,
    input  logic              undr_clr,
    input  logic              rst_es,
    input  logic [IE_W-1:0]   ie_mask,
    input  logic              async_mode,
    input  logic              xtal_sel,
    input  logic              mie,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    logic              pend;
    logic              force_sync;
    logic [NLINE-1:0]  shown;
    logic [NLINE-1:0]  change;
    logic              eom_flag;
    logic              eom_rise;
    logic              brk_q;
    logic              brk_edge;

    // Sync/hunt is forced off for asynchronous operation on the crystal option.
    always_comb force_sync = async_mode & xtal_sel;

    for (genvar i = 0; i < NLINE; i++) begin : g_line
        logic frc;
        logic live;
        // Pick the force for this line and form its active-high live value.
        always_comb begin
            frc  = (i == LN_SYNC) ? force_sync : 1'b0;
            live = ~line_n[i] & ~frc;
        end
        extstat_line u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .live      (live),
            .en        (ie_mask[i]),
            .hold      (pend),
            .force_off (frc),
            .shown     (shown[i]),
            .change    (change[i])
        );
    end

    extstat_eom u_eom (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (eom_set),
        .clr   (undr_clr),
        .en    (ie_mask[IE_UNDR]),
        .flag  (eom_flag),
        .rise  (eom_rise)
    );

    // Register the break level so that both of its edges can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n)
            brk_q <= 1'b0;
        else
            brk_q <= brk_det;
    end

    // An enabled break edge in either direction.
    always_comb brk_edge = ie_mask[IE_BRK] & (brk_det ^ brk_q);

    extstat_pend u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_set (|change),
        .eom_rise (eom_rise),
        .brk_edge (brk_edge),
        .rst_es   (rst_es),
        .pend     (pend)
    );

    // Assemble the status byte and gate the request.
    always_comb begin
        status = {brk_q, eom_flag, shown, zero_cnt, tx_buf_empty, rx_char_avail};
        irq    = pend & mie;
    end
endmodule

// File: rtl/extstat_latch_chk.sv
// Port-level temporal checks for extstat_latch, attached with bind.
module extstat_latch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] line_n,
    input logic       brk_det,
    input logic       eom_set,
    input logic       undr_clr,
    input logic       rst_es,
    input logic [4:0] ie_mask,
    input logic       async_mode,
    input logic       xtal_sel,
    input logic       mie,
    input logic [7:0] status,
    input logic       irq
);
    p_eom_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eom_set |=> status[6]);

    p_eom_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (undr_clr && !eom_set) |=> !status[6]);

    p_brk_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_mask[4] && brk_det != status[7]) |=> (!mie || irq));

    p_cts_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && ie_mask[2] && !rst_es) |=> (!ie_mask[2] || $stable(status[5])));

    p_sync_forced_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (async_mode && xtal_sel) |-> !status[4]);

    p_line_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_mask[2:0] == 3'b000 && !(async_mode && xtal_sel)) |-> (status[5:3] == ~line_n));

    p_mie_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mie |-> !irq);
endmodule

bind extstat_latch extstat_latch_chk u_chk (.*);

// File: tb/extstat_latch_bench.sv
`timescale 1ns/1ps
module extstat_latch_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] line_n;
    logic       brk_det, zero_cnt, tx_buf_empty, rx_char_avail;
    logic       eom_set, undr_clr, rst_es;
    logic [4:0] ie_mask;
    logic       async_mode, xtal_sel, mie;
    logic [7:0] status;
    logic       irq;
    int         n_vec = 0;
    int         n_bad = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    extstat_latch u_extstat_latch (
        .clk(clk), .rst_n(rst_n), .line_n(line_n), .brk_det(brk_det),
        .zero_cnt(zero_cnt), .tx_buf_empty(tx_buf_empty), .rx_char_avail(rx_char_avail),
        .eom_set(eom_set), .undr_clr(undr_clr), .rst_es(rst_es), .ie_mask(ie_mask),
        .async_mode(async_mode), .xtal_sel(xtal_sel), .mie(mie),
        .status(status), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Clear any pending request and let all lines settle to idle.
    task automatic settle(input logic [4:0] keep_ie);
        ie_mask = 5'b0;
        line_n  = 3'b111;
        rst_es  = 1'b1;
        step();
        rst_es  = 1'b0;
        step();
        step();
        ie_mask = keep_ie;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; line_n = 3'b111; brk_det = 0; zero_cnt = 0; tx_buf_empty = 0;
        rx_char_avail = 0; eom_set = 0; undr_clr = 0; rst_es = 0; ie_mask = 0;
        async_mode = 0; xtal_sel = 0; mie = 1;
        step(); step();
        chk("R2 reset byte", status, 8'h40);
        chk("R2 reset irq", {7'b0, irq}, 8'h0);
        rst_n = 1;
        step();
        chk("R2 after release", status, 8'h40);

        // R1: pass-through bits, all combinations.
        for (int v = 0; v < 8; v++) begin
            {zero_cnt, tx_buf_empty, rx_char_avail} = v[2:0];
            #1;
            chk("R1 low bits", {5'b0, status[2:0]}, {5'b0, v[2:0]});
        end
        {zero_cnt, tx_buf_empty, rx_char_avail} = 3'b0;

        // R6: masked lines read live and inverted, never request.
        for (int v = 0; v < 8; v++) begin
            line_n = v[2:0];
            #1;
            chk("R6 live view", {5'b0, status[5:3]}, {5'b0, ~v[2:0]});
            step();
            chk("R6 no irq", {7'b0, irq}, 8'h0);
        end
        settle(5'b0);

        // R3/R4/R5: each line, 0..3 toggles while a request is pending.
        for (int p = 0; p < 3; p++) begin
            for (int k = 0; k < 4; k++) begin
                settle(5'b1 << p);
                line_n[p] = 1'b0;
                step();
                chk("R3 capture irq", {7'b0, irq}, 8'h1);
                chk("R3 capture bit", {7'b0, status[3+p]}, 8'h1);
                for (int t = 0; t < k; t++) begin
                    line_n[p] = ~line_n[p];
                    step();
                    chk("R4 held bit", {7'b0, status[3+p]}, 8'h1);
                end
                rst_es = 1'b1;
                step();
                rst_es = 1'b0;
                chk("R5 release clears", {7'b0, irq}, 8'h0);
                step();
                chk("R5 parity re-arm", {7'b0, irq}, {7'b0, k[0]});
            end
        end
        settle(5'b0);

        // R7: break both edges, during pending and with release.
        ie_mask = 5'b10000;
        brk_det = 1; step();
        chk("R7 rise irq", {7'b0, irq}, 8'h1);
        chk("R7 bit", {7'b0, status[7]}, 8'h1);
        rst_es = 1; step(); rst_es = 0;
        chk("R7 released", {7'b0, irq}, 8'h0);
        brk_det = 0; step();
        chk("R7 fall irq", {7'b0, irq}, 8'h1);
        brk_det = 1; step();
        brk_det = 0; step();
        rst_es = 1; step(); rst_es = 0;
        chk("R7 owed after release", {7'b0, irq}, 8'h1);
        rst_es = 1; step(); rst_es = 0;
        chk("R7 second release", {7'b0, irq}, 8'h0);
        brk_det = 1; rst_es = 1; step(); rst_es = 0;
        chk("R7 edge with release", {7'b0, irq}, 8'h1);
        rst_es = 1; step(); rst_es = 0;
        brk_det = 0; step();
        rst_es = 1; step(); rst_es = 0;
        chk("R7 cleaned", {7'b0, irq}, 8'h0);

        // R8: underrun/EOM latch.
        ie_mask = 5'b01000;
        chk("R8 reset value", {7'b0, status[6]}, 8'h1);
        undr_clr = 1; step(); undr_clr = 0;
        chk("R8 cleared", {7'b0, status[6]}, 8'h0);
        chk("R8 clear no irq", {7'b0, irq}, 8'h0);
        eom_set = 1; step(); eom_set = 0;
        chk("R8 set bit", {7'b0, status[6]}, 8'h1);
        chk("R8 rise irq", {7'b0, irq}, 8'h1);
        rst_es = 1; step(); rst_es = 0;
        eom_set = 1; step(); eom_set = 0;
        chk("R8 set when set no irq", {7'b0, irq}, 8'h0);
        eom_set = 1; undr_clr = 1; step(); eom_set = 0; undr_clr = 0;
        chk("R8 set wins", {7'b0, status[6]}, 8'h1);
        undr_clr = 1; step(); undr_clr = 0;
        ie_mask = 5'b0;
        eom_set = 1; step(); eom_set = 0;
        chk("R8 masked rise", {7'b0, irq}, 8'h0);
        chk("R8 masked bit", {7'b0, status[6]}, 8'h1);

        // R9: sync forced off only for async with crystal.
        settle(5'b00010);
        async_mode = 1; xtal_sel = 1; line_n[1] = 0;
        #1;
        chk("R9 forced bit", {7'b0, status[4]}, 8'h0);
        step();
        chk("R9 forced no irq", {7'b0, irq}, 8'h0);
        xtal_sel = 0; step();
        chk("R9 unforced irq", {7'b0, irq}, 8'h1);
        chk("R9 unforced bit", {7'b0, status[4]}, 8'h1);
        async_mode = 0; xtal_sel = 1;
        settle(5'b00010);
        line_n[1] = 0; step();
        chk("R9 sync mode irq", {7'b0, irq}, 8'h1);
        xtal_sel = 0;
        settle(5'b0);

        // R10: master enable gates but does not discard.
        ie_mask = 5'b00100; mie = 0;
        line_n[2] = 0; step();
        chk("R10 gated", {7'b0, irq}, 8'h0);
        mie = 1; #1;
        chk("R10 kept", {7'b0, irq}, 8'h1);
        settle(5'b0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule